// File: doc/BRIEF.md
# Phase-Wrapped Sine/Cosine Lookup Unit

This block turns a signed fixed-point phase into the cosine and sine of that phase. Together they form the real and imaginary parts of a complex exponential of unit magnitude. Any phase between -4 and +4 is accepted. Because both functions repeat every 2*pi, the phase is first folded into the interval -pi..pi. The folded phase is then rounded to one of 629 table points spaced 0.01 rad apart, and a registered lookup memory returns the cosine and sine stored at that point.

The path has two register stages. The first stage folds the phase and computes the table index. The second stage reads the table. A valid flag travels alongside the data. While no new sample is being read, the output pair holds its last value. The table is computed during elaboration from the width parameters, so the 8-, 16- and 32-bit variants need no external data.

Top module: `sincos_lut`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and cos_o and sin_o are 0. A valid_i held high during reset leaves no trace after release.
- R2: valid_o is high in exactly those cycles that come two clock edges after a cycle in which valid_i was high at the clock edge.
- R3: The phase is folded as follows. If it exceeds pi rounded to the phase grid, 2*pi rounded to the phase grid is subtracted. If it is below minus that rounded pi, the rounded 2*pi is added. Otherwise it is unchanged.
- R4: phase_i is two's complement with 13 fraction bits (Q2.13). The table index is floor((folded + 3.14) * 100 + 0.5), clamped to 0..628. Index 0 stands for -3.14 rad and index k for -3.14 + 0.01*k rad.
- R5: The output pair is taken from entry k. cos_o = round(cos(-3.14 + 0.01*k) * 2^14) and sin_o = round(sin(-3.14 + 0.01*k) * 2^14), both two's complement Q1.14 and within -1..+1 inclusive.
- R6: For every input code, |cos_o - cos(phase)| and |sin_o - sin(phase)| are at most 0.01 + 2^-14.
- R7: In a cycle where valid_o is low, cos_o and sin_o keep the values they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies phase_i in this cycle |
| phase_i | input | PHASE_W (16) | Signed phase, PHASE_FRAC fraction bits |
| valid_o | output | 1 | cos_o/sin_o carry a new result |
| cos_o | output | OUT_W (16) | Signed cosine, OUT_FRAC fraction bits |
| sin_o | output | OUT_W (16) | Signed sine, OUT_FRAC fraction bits |

## Verification
The assertions assume three things: valid_i is a known level at every clock edge after reset, reset is released away from a clock edge, and any 16-bit phase code is legal. The last holds because Q2.13 spans exactly -4 to just under +4, so folding a single time always suffices.

The stimulus changes inputs only on the falling edge and releases reset there. It draws phase codes from the whole 16-bit word, so every code is a legal input. It also adds directed codes at the word extremes, on both sides of the rounded pi thresholds, and at an exact half-step rounding tie.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  localparam real PI         = 3.14159265358979323846;
  localparam real TAB_FIRST  = -3.14;
  localparam real TAB_STEP   = 0.01;
  localparam int  TAB_DEPTH  = 629;
  localparam int  TAB_ORIGIN = 314;  // index of angle 0
  localparam int  TAB_SCALE  = 100;  // 1 / TAB_STEP

  // real -> fixed point, round to nearest
  function automatic longint fix_round(real x, int frac);
    real s;
    s = x * (2.0 ** frac);
    return longint'(s);
  endfunction
endpackage

// File: rtl/sincos_fold_index.sv
module sincos_fold_index
  import sincos_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int PHASE_FRAC = 13,
  parameter int IDX_W      = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [PHASE_W-1:0] phase_i,
  output logic                      valid_o,
  output logic        [IDX_W-1:0]   idx_o
);
  localparam int IW = PHASE_FRAC + 6;   // sign + 5 integer bits
  localparam int MW = PHASE_FRAC + 12;  // room for *100 plus offset
  localparam int QW = MW - PHASE_FRAC;

  localparam logic signed [IW-1:0] PI_Q     = IW'(fix_round(PI, PHASE_FRAC));
  localparam logic signed [IW-1:0] TWO_PI_Q = IW'(fix_round(2.0 * PI, PHASE_FRAC));
  localparam logic signed [MW-1:0] SCALE_Q  = MW'(TAB_SCALE);
  localparam logic signed [MW-1:0] BIAS_Q   =
    MW'((longint'(TAB_ORIGIN) << PHASE_FRAC) + (longint'(1) << (PHASE_FRAC - 1)));
  localparam logic signed [QW-1:0] LAST_Q   = QW'(TAB_DEPTH - 1);

  logic signed [IW-1:0] ph_ext, folded;
  logic signed [MW-1:0] num;
  logic signed [QW-1:0] q;
  logic        [IDX_W-1:0] idx_d;

  always_comb begin
    ph_ext = {{(IW-PHASE_W){phase_i[PHASE_W-1]}}, phase_i};
    if (ph_ext > PI_Q)       folded = ph_ext - TWO_PI_Q;
    else if (ph_ext < -PI_Q) folded = ph_ext + TWO_PI_Q;
    else                     folded = ph_ext;
    num = MW'(folded) * SCALE_Q + BIAS_Q;
    q   = QW'(num >>> PHASE_FRAC);
    if (q < 0)            idx_d = '0;
    else if (q > LAST_Q)  idx_d = IDX_W'(TAB_DEPTH - 1);
    else                  idx_d = IDX_W'(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) idx_o <= idx_d;
    end
  end
endmodule

// File: rtl/sincos_table.sv
module sincos_table
  import sincos_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 14,
  parameter int IDX_W    = 10,
  parameter int DEPTH    = TAB_DEPTH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic        [IDX_W-1:0] idx_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  logic signed [2*OUT_W-1:0] tab [DEPTH];

  // entry = {cos, sin}, computed at elaboration
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam real ANG = TAB_FIRST + TAB_STEP * k;
    assign tab[k] = {OUT_W'(fix_round($cos(ANG), OUT_FRAC)),
                     OUT_W'(fix_round($sin(ANG), OUT_FRAC))};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cos_o   <= '0;
      sin_o   <= '0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) {cos_o, sin_o} <= tab[idx_i];
    end
  end
endmodule

// File: rtl/sincos_lut.sv
module sincos_lut
  import sincos_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int PHASE_FRAC = 13,
  parameter int OUT_W      = 16,
  parameter int OUT_FRAC   = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [PHASE_W-1:0] phase_i,
  output logic                      valid_o,
  output logic signed [OUT_W-1:0]   cos_o,
  output logic signed [OUT_W-1:0]   sin_o
);
  localparam int IDX_W = $clog2(TAB_DEPTH);

  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;

  sincos_fold_index #(
    .PHASE_W   (PHASE_W),
    .PHASE_FRAC(PHASE_FRAC),
    .IDX_W     (IDX_W)
  ) i_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .phase_i(phase_i),
    .valid_o(s1_valid),
    .idx_o  (s1_idx)
  );

  sincos_table #(
    .OUT_W   (OUT_W),
    .OUT_FRAC(OUT_FRAC),
    .IDX_W   (IDX_W),
    .DEPTH   (TAB_DEPTH)
  ) i_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (s1_valid),
    .idx_i  (s1_idx),
    .valid_o(valid_o),
    .cos_o  (cos_o),
    .sin_o  (sin_o)
  );
endmodule

// File: rtl/sincos_lut_chk.sv
module sincos_lut_chk #(
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 14,
  parameter int IDX_W    = 10,
  parameter int DEPTH    = 629
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    s1_valid,
  input logic        [IDX_W-1:0] s1_idx,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] cos_o,
  input logic signed [OUT_W-1:0] sin_o
);
  localparam logic signed [OUT_W-1:0] ONE = OUT_W'(longint'(1) << OUT_FRAC);
  localparam logic        [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && cos_o == '0 && sin_o == '0)); // R1

  AST_STAGE1_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid); // R2

  AST_STAGE1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !s1_valid); // R2

  AST_OUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> valid_o); // R2

  AST_OUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !valid_o); // R2

  AST_INDEX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> s1_idx <= LAST); // R4

  AST_UNIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cos_o <= ONE && cos_o >= -ONE && sin_o <= ONE && sin_o >= -ONE)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> ($stable(cos_o) && $stable(sin_o))); // R7
endmodule

bind sincos_lut sincos_lut_chk #(
  .OUT_W   (OUT_W),
  .OUT_FRAC(OUT_FRAC),
  .IDX_W   (IDX_W),
  .DEPTH   (sincos_pkg::TAB_DEPTH)
) i_sincos_lut_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .s1_valid(s1_valid),
  .s1_idx  (s1_idx),
  .valid_o (valid_o),
  .cos_o   (cos_o),
  .sin_o   (sin_o)
);

// File: tb/test_sincos_lut.sv
module test_sincos_lut;
  localparam real TOL = 0.01 + 1.0 / 16384.0;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               valid_i;
  logic        [15:0] phase_i;
  logic               valid_o;
  logic signed [15:0] cos_o, sin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        pv1 = 1'b0, pv2 = 1'b0;
  logic [15:0] pp1 = '0, pp2 = '0;
  logic signed [15:0] last_cos = '0, last_sin = '0;

  always #4 clk_i = ~clk_i;

  sincos_lut i_sincos_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .phase_i(phase_i),
    .valid_o(valid_o),
    .cos_o  (cos_o),
    .sin_o  (sin_o)
  );

  function automatic int rnd(real x);
    return int'($floor(x + 0.5));
  endfunction

  // R3 R4: fold on rounded pi grid, then index
  function automatic int exp_idx(logic [15:0] ph);
    int m, k, piq, tpq;
    piq = rnd(3.141592653589793 * 8192.0);
    tpq = rnd(2.0 * 3.141592653589793 * 8192.0);
    m = int'($signed(ph));
    if (m > piq)       m = m - tpq;
    else if (m < -piq) m = m + tpq;
    k = int'($floor(real'(m) * 100.0 / 8192.0 + 314.0 + 0.5));
    if (k < 0)   k = 0;
    if (k > 628) k = 628;
    return k;
  endfunction

  function automatic real absr(real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic check_out(input logic v, input logic [15:0] ph);
    int k, ec, es;
    real p, dc, ds;
    checks++;
    if (valid_o !== v) begin
      errors++;
      $display("FAIL R2 valid_o phase=%h got %b exp %b", ph, valid_o, v);
    end
    if (v) begin
      k  = exp_idx(ph);
      ec = rnd($cos(-3.14 + 0.01 * k) * 16384.0);
      es = rnd($sin(-3.14 + 0.01 * k) * 16384.0);
      checks++;  // R4 R5 exact entry
      if (cos_o !== 16'(ec) || sin_o !== 16'(es)) begin
        errors++;
        $display("FAIL R5 phase=%h idx=%0d got cos=%0d sin=%0d exp cos=%0d sin=%0d",
                 ph, k, cos_o, sin_o, ec, es);
      end
      p  = real'($signed(ph)) / 8192.0;
      dc = absr(real'(cos_o) / 16384.0 - $cos(p));
      ds = absr(real'(sin_o) / 16384.0 - $sin(p));
      checks++;
      if (dc > TOL || ds > TOL) begin
        errors++;
        $display("FAIL R6 phase=%h got cos=%0d sin=%0d exp cos=%f sin=%f",
                 ph, cos_o, sin_o, $cos(p), $sin(p));
      end
      last_cos = cos_o;
      last_sin = sin_o;
    end else begin
      checks++;
      if (cos_o !== last_cos || sin_o !== last_sin) begin
        errors++;
        $display("FAIL R7 hold got cos=%0d sin=%0d exp cos=%0d sin=%0d",
                 cos_o, sin_o, last_cos, last_sin);
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] ph);
    @(negedge clk_i);
    check_out(pv2, pp2);
    pv2 = pv1; pp2 = pp1;
    pv1 = v;   pp1 = ph;
    valid_i = v;
    phase_i = ph;
  endtask

  initial begin
    int seed;
    logic [15:0] dir [10];
    rst_ni  = 1'b0;
    valid_i = 1'b1;
    phase_i = 16'h1234;
    seed = int'($urandom(32'd2024));
    // R1: outputs quiet during reset even with valid_i high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      checks++;
      if (valid_o !== 1'b0 || cos_o !== 16'sd0 || sin_o !== 16'sd0) begin
        errors++;
        $display("FAIL R1 reset got v=%b cos=%0d sin=%0d exp 0 0 0",
                 valid_o, cos_o, sin_o);
      end
    end
    @(negedge clk_i);
    rst_ni  = 1'b1;
    valid_i = 1'b0;

    // directed: extremes, rounded-pi edges (R3), half-step tie (R4)
    dir = '{16'h8000, 16'h7FFF, 16'h0000, 16'd25736, 16'd25737,
            16'hFFFF & (-16'd25736), 16'hFFFF & (-16'd25737),
            16'd1024, 16'hFFFF & (-16'd24576), 16'd25735};
    for (int i = 0; i < 10; i++) step(1'b1, dir[i]);
    step(1'b0, 16'h0);
    step(1'b0, 16'h0);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, dir[i]);
      step(1'b0, 16'h4444);
    end

    // full sweep -4..4 in coarse steps
    for (int i = 0; i < 512; i++) step(1'b1, 16'(i * 128));

    // random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 16'($urandom));

    step(1'b0, 16'h0);
    step(1'b0, 16'h0);
    step(1'b0, 16'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule